// File: doc/BRIEF.md
# Full-Period 16-bit Pseudo-Random Sequence Generator

This block produces a pseudo-random word sequence from a 16-bit maximal-length shift register. On every cycle with the step enable high, the register shifts one position toward its most significant end. A feedback bit formed from four tap positions enters at bit 0. When the step enable is low, the register holds. A synchronous reset loads a fixed non-degenerate seed and clears a flag. That flag rises on the first step after reset and tells the consumer that the outputs have moved away from the seed.

A parameter selects parity (XOR) feedback or inverted-parity (XNOR) feedback. The choice decides which word is the self-mapping lockup word: all zeros for XOR, all ones for XNOR. A second parameter adds a small correction so the sequence runs through all 65536 words. When the register holds the word one step before the lockup word, the correction inverts the feedback bit. The register then enters the lockup word and leaves it on the next step. Without the correction, the sequence is 65535 words long and never reaches the lockup word.

The full word is presented on one output, and its upper and lower bytes on two more outputs. Consumers can therefore take either a 16-bit value or two 8-bit values per step.

Top module: `prng16_gen`

## Requirements
- R1: On every enabled cycle without reset, the next state is the old state shifted up by one: new bits 15..1 equal old bits 14..0, and the feedback bit enters at bit 0.
- R2: The linear feedback bit is the XOR of state bits 15, 14, 12 and 3 (taps 16, 15, 13, 4). In XNOR mode (FB_MODE = FB_XNOR) it is the complement of that XOR.
- R3: With the step enable low and reset low, the state and all outputs keep their values.
- R4: Reset is synchronous and has priority over the step enable. It loads the seed 0x0001 (bit 0 set, all other bits clear).
- R5: The stepped flag is 0 after reset. It is 1 after the first enabled cycle and stays 1 until the next reset.
- R6: The full state appears on state_o, state bits 15..8 on hi_byte_o, and state bits 7..0 on lo_byte_o.
- R7: With XOR feedback and no correction, the seed returns after exactly 65535 steps, and the all-zeros word never appears.
- R8: With the correction enabled, the feedback bit is inverted whenever state bits 14..0 equal bits 14..0 of the lockup word. In XOR mode this gives 0x8000 -> 0x0000 -> 0x0001. In XNOR mode it gives 0x7FFF -> 0xFFFF -> 0xFFFE. The seed returns after exactly 65536 steps, and the lockup word appears exactly once in that walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, overrides step_en |
| step_en | input | 1 | Advance the register by one position this cycle |
| state_o | output | 16 | Current register word |
| hi_byte_o | output | 8 | Register bits 15..8 |
| lo_byte_o | output | 8 | Register bits 7..0 |
| stepped_o | output | 1 | At least one step has run since reset |

## Verification
The bench builds three copies side by side, all driven by the same inputs. The first uses the default XOR feedback with no correction. The second uses XOR feedback with the full-period correction. The third uses XNOR feedback with the correction. The default copy reaches the 65535-word period and shows that all zeros never appears. The two corrected copies reach the inserted lockup word from both ends (all zeros and all ones), the exact 65536-word period, and a single visit to the lockup word. The same walk also checks the XNOR tap polarity on every step against a model written from the requirements.

// File: rtl/prng16_pkg.sv
package prng16_pkg;

   typedef enum logic {
      FB_XOR  = 1'b0,
      FB_XNOR = 1'b1
   } fb_mode_e;

endpackage

// File: rtl/prng16_feedback.sv
module prng16_feedback
   import prng16_pkg::*;
#(
   parameter int           WIDTH       = 16,
   parameter logic [WIDTH-1:0] TAP_MASK = 16'hD008,
   parameter fb_mode_e     FB_MODE     = FB_XOR,
   parameter bit           FULL_PERIOD = 1'b0
) (
   input  logic [WIDTH-1:0] cur_state,
   output logic             fb_bit
);

   localparam logic [WIDTH-1:0] LOCKUP = (FB_MODE == FB_XNOR) ? '1 : '0;

   logic parity;
   logic fb_lin;

   // parity of the tapped bits (R2)
   assign parity = ^(cur_state & TAP_MASK);

   generate
      if (FB_MODE == FB_XNOR) begin : g_xnor
         assign fb_lin = ~parity;
      end else begin : g_xor
         assign fb_lin = parity;
      end

      if (FULL_PERIOD) begin : g_full
         logic near_lock;
         // low bits match the lockup word: steer into or out of it (R8)
         assign near_lock = (cur_state[WIDTH-2:0] == LOCKUP[WIDTH-2:0]);
         assign fb_bit    = fb_lin ^ near_lock;
      end else begin : g_plain
         assign fb_bit = fb_lin;
      end
   endgenerate

endmodule

// File: rtl/prng16_step_reg.sv
module prng16_step_reg #(
   parameter int               WIDTH = 16,
   parameter logic [WIDTH-1:0] SEED  = 16'h0001
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic             fb_bit,
   output logic [WIDTH-1:0] state_q,
   output logic             stepped_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= SEED;
         stepped_q <= 1'b0;
      end else if (step_en) begin
         state_q   <= {state_q[WIDTH-2:0], fb_bit};
         stepped_q <= 1'b1;
      end
   end

   p_shift_r1: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])));

   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(state_q));

   p_done_set_r5: assert property (@(posedge clk) disable iff (rst)
      step_en |=> stepped_q);

   p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      stepped_q |=> stepped_q);

endmodule

// File: rtl/prng16_gen.sv
module prng16_gen
   import prng16_pkg::*;
#(
   parameter int               WIDTH       = 16,
   parameter logic [WIDTH-1:0] TAP_MASK    = 16'hD008,
   parameter logic [WIDTH-1:0] SEED        = 16'h0001,
   parameter fb_mode_e         FB_MODE     = FB_XOR,
   parameter bit               FULL_PERIOD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step_en,
   output logic [WIDTH-1:0]     state_o,
   output logic [WIDTH/2-1:0]   hi_byte_o,
   output logic [WIDTH/2-1:0]   lo_byte_o,
   output logic                 stepped_o
);

   localparam int               HALF   = WIDTH / 2;
   localparam logic [WIDTH-1:0] LOCKUP = (FB_MODE == FB_XNOR) ? '1 : '0;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("prng16_gen: WIDTH must be even and at least 4");
      end
      if (SEED == LOCKUP) begin : g_bad_seed
         $error("prng16_gen: SEED equals the lockup word of the chosen feedback mode");
      end
      if (TAP_MASK[WIDTH-1] == 1'b0) begin : g_bad_taps
         $error("prng16_gen: TAP_MASK must include the top bit");
      end
   endgenerate

   logic [WIDTH-1:0] state_q;
   logic             fb_bit;
   logic             stepped_q;

   prng16_feedback #(
      .WIDTH       (WIDTH),
      .TAP_MASK    (TAP_MASK),
      .FB_MODE     (FB_MODE),
      .FULL_PERIOD (FULL_PERIOD)
   ) u_fb (
      .cur_state (state_q),
      .fb_bit    (fb_bit)
   );

   prng16_step_reg #(
      .WIDTH (WIDTH),
      .SEED  (SEED)
   ) u_reg (
      .clk       (clk),
      .rst       (rst),
      .step_en   (step_en),
      .fb_bit    (fb_bit),
      .state_q   (state_q),
      .stepped_q (stepped_q)
   );

   // output views (R6)
   assign state_o   = state_q;
   assign hi_byte_o = state_q[WIDTH-1:HALF];
   assign lo_byte_o = state_q[HALF-1:0];
   assign stepped_o = stepped_q;

   generate
      if (FULL_PERIOD) begin : g_chk_full
         p_leave_lockup_r8: assert property (@(posedge clk) disable iff (rst)
            (step_en && state_q == LOCKUP) |=> (state_q != LOCKUP));
      end else begin : g_chk_plain
         p_no_lockup_r7: assert property (@(posedge clk) disable iff (rst)
            state_q != LOCKUP);
      end
   endgenerate

endmodule

// File: tb/prng16_gen_tb.sv
`timescale 1ns/1ps
module prng16_gen_tb;
   import prng16_pkg::*;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic step_en = 1'b0;

   always #4 clk = ~clk;

   logic [15:0] st_a, st_b, st_c;
   logic [7:0]  hi_a, lo_a, hi_b, lo_b, hi_c, lo_c;
   logic        dn_a, dn_b, dn_c;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   prng16_gen u_dut (
      .clk(clk), .rst(rst), .step_en(step_en),
      .state_o(st_a), .hi_byte_o(hi_a), .lo_byte_o(lo_a), .stepped_o(dn_a));

   prng16_gen #(.FB_MODE(FB_XOR), .FULL_PERIOD(1'b1)) u_dut_xf (
      .clk(clk), .rst(rst), .step_en(step_en),
      .state_o(st_b), .hi_byte_o(hi_b), .lo_byte_o(lo_b), .stepped_o(dn_b));

   prng16_gen #(.FB_MODE(FB_XNOR), .FULL_PERIOD(1'b1)) u_dut_nf (
      .clk(clk), .rst(rst), .step_en(step_en),
      .state_o(st_c), .hi_byte_o(hi_c), .lo_byte_o(lo_c), .stepped_o(dn_c));

   function automatic logic [15:0] model_next(logic [15:0] s, bit xn, bit full);
      logic f;
      f = s[15] ^ s[14] ^ s[12] ^ s[3];
      if (xn) f = ~f;
      if (full && s[14:0] == (xn ? 15'h7FFF : 15'h0000)) f = ~f;
      return {s[14:0], f};
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1; step_en = 1'b0;
      tick(); tick();
      check(st_a == 16'h0001, "R4", "seed xor", st_a, 16'h0001);
      check(st_c == 16'h0001, "R4", "seed xnor", st_c, 16'h0001);
      check(dn_a == 1'b0 && dn_c == 1'b0, "R5", "flag after reset", {dn_a, dn_c}, 0);
      check(hi_a == 8'h00 && lo_a == 8'h01, "R6", "byte split seed", {hi_a, lo_a}, 16'h0001);
      rst = 1'b0;
      tick();
      check(st_a == 16'h0001 && dn_a == 1'b0, "R3", "idle after reset", st_a, 16'h0001);
   endtask

   task automatic t_first_steps();
      logic [15:0] ea, eb, ec;
      ea = st_a; eb = st_b; ec = st_c;
      step_en = 1'b1;
      for (int k = 0; k < 24; k++) begin
         ea = model_next(ea, 1'b0, 1'b0);
         eb = model_next(eb, 1'b0, 1'b1);
         ec = model_next(ec, 1'b1, 1'b1);
         tick();
         check(st_a == ea, "R1", "xor step", st_a, ea);
         check(st_c == ec, "R2", "xnor step", st_c, ec);
         check(st_b == eb, "R2", "xor full step", st_b, eb);
         check(hi_a == ea[15:8] && lo_a == ea[7:0], "R6", "bytes", {hi_a, lo_a}, ea);
         check(dn_a && dn_b && dn_c, "R5", "flag set", {dn_a, dn_b, dn_c}, 3'b111);
      end
      step_en = 1'b0;
   endtask

   task automatic t_hold();
      logic [15:0] ha, hc;
      ha = st_a; hc = st_c;
      for (int k = 0; k < 5; k++) begin
         tick();
         check(st_a == ha && st_c == hc, "R3", "hold", st_a, ha);
         check(dn_a == 1'b1, "R5", "flag stays", dn_a, 1);
      end
   endtask

   task automatic t_reset_priority();
      rst = 1'b1; step_en = 1'b1;
      tick();
      check(st_a == 16'h0001 && st_b == 16'h0001 && st_c == 16'h0001,
            "R4", "reset over enable", st_a, 16'h0001);
      check(dn_a == 1'b0, "R5", "flag cleared", dn_a, 0);
      rst = 1'b0; step_en = 1'b0;
      tick();
   endtask

   task automatic t_period_walk();
      logic [15:0] ea, eb, ec;
      int ret_a = 0, ret_b = 0, ret_c = 0;
      int zero_a = 0, zero_b = 0, ones_c = 0;
      int mism = 0;
      ea = st_a; eb = st_b; ec = st_c;
      step_en = 1'b1;
      for (int k = 1; k <= 65536; k++) begin
         ea = model_next(ea, 1'b0, 1'b0);
         eb = model_next(eb, 1'b0, 1'b1);
         ec = model_next(ec, 1'b1, 1'b1);
         tick();
         if (st_a != ea || st_b != eb || st_c != ec) begin
            if (mism == 0)
               check(1'b0, "R8", "walk vs model", {st_b, st_c}, {eb, ec});
            mism++;
         end
         if (st_a == 16'h0001 && ret_a == 0) ret_a = k;
         if (st_b == 16'h0001 && ret_b == 0) ret_b = k;
         if (st_c == 16'h0001 && ret_c == 0) ret_c = k;
         if (st_a == 16'h0000) zero_a++;
         if (ret_b == 0 && st_b == 16'h0000) zero_b++;
         if (ret_c == 0 && st_c == 16'hFFFF) ones_c++;
      end
      step_en = 1'b0;
      check(mism == 0, "R8", "walk mismatches", mism, 0);
      check(ret_a == 65535, "R7", "xor period", ret_a, 65535);
      check(zero_a == 0, "R7", "zeros never seen", zero_a, 0);
      check(ret_b == 65536, "R8", "xor full period", ret_b, 65536);
      check(zero_b == 1, "R8", "zeros once", zero_b, 1);
      check(ret_c == 65536, "R8", "xnor full period", ret_c, 65536);
      check(ones_c == 1, "R8", "ones once", ones_c, 1);
   endtask

   task automatic t_insertion_points();
      // r8_ corner words computed by hand
      check(model_next(16'h8000, 1'b0, 1'b1) == 16'h0000, "R8", "8000 to 0000",
            model_next(16'h8000, 1'b0, 1'b1), 16'h0000);
      check(model_next(16'h7FFF, 1'b1, 1'b1) == 16'hFFFF, "R8", "7FFF to FFFF",
            model_next(16'h7FFF, 1'b1, 1'b1), 16'hFFFF);
   endtask

   initial begin
      t_reset();
      t_first_steps();
      t_hold();
      t_reset_priority();
      t_insertion_points();
      t_period_walk();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8ns * 190000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule